// File: doc/BRIEF.md
# Running Rank-Order Filter with Age-Tagged Sorted Window

This block is a streaming rank-order filter. It holds a sliding window of `2*HALF+1` samples in a linear array of slots, and it keeps the slots sorted by value at all times. Slot 0 holds the smallest value. Each slot also carries an age tag. When a sample is accepted, one cycle does three things. The sample with the largest age is removed wherever it sits, the new sample is placed at its sorted position, and every age is updated. The filter emits the value at a configurable rank, which is the median when the rank is `HALF`.

Each slot decides its next content locally. It uses its own comparison against the broadcast input sample, the comparisons of its two neighbours, and whether it lies below, at or above the slot being evicted. From these it either holds, takes its lower neighbour's content, takes its upper neighbour's content, or loads the new sample.

Static configuration inputs control three things:
- whether comparisons are signed or unsigned;
- whether the filter runs recursively, so that the emitted value is refreshed as if it were a new sample;
- whether the filter runs in two-dimensional mode, where only every `SHIFT_LEN`-th accepted sample produces an output.

When equal values are present, a new sample is placed above all stored values that equal it.

Top module: `rank_median_filter`

## Requirements
- R1: After every update the window is sorted in non-decreasing order under the active comparison, so rank 0 yields the window minimum and rank `2*HALF` yields the maximum.
- R2: In standard mode each accepted sample evicts the oldest window entry, so the window always equals the last `2*HALF+1` accepted samples, counting the reset preload as the oldest ones.
- R3: `cfg_rank` selects the output slot. A value above `2*HALF` selects slot `2*HALF`. The value `HALF` gives the median.
- R4: With `cfg_signed`=1, samples are ordered as two's-complement numbers; with `cfg_signed`=0, they are ordered as unsigned numbers.
- R5: After reset the window holds `2*HALF+1` zero samples with distinct ages, slot `2*HALF` being the oldest. Both `out_valid` and `out_data` are 0.
- R6: The result for an accepted sample appears on the cycle after it is accepted. `out_valid` stays low until `2*HALF+1` samples have been accepted since reset.
- R7: A cycle with `in_valid`=0 changes neither window contents nor ages, and it drives `out_valid` low on the next cycle.
- R8: In recursive mode, before each insertion the age of the slot at the selected rank is cleared. Ages saturate at `2^AW-1`, where AW = clog2(`2*HALF+1`)+2. When several entries tie for the largest age, the lowest slot index is evicted.
- R9: In two-dimensional mode, accepted samples are counted modulo `SHIFT_LEN` from reset, and only the sample that completes each group produces `out_valid`, provided the fill condition of R6 also holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | W | Input sample |
| cfg_signed | input | 1 | 1: two's-complement ordering |
| cfg_recursive | input | 1 | 1: recursive filtering |
| cfg_2d | input | 1 | 1: one output per group of SHIFT_LEN samples |
| cfg_rank | input | clog2(2*HALF+1) | Output rank selection |
| out_valid | output | 1 | Output sample present |
| out_data | output | W | Value at the selected rank |

## Verification
The window is driven with several input patterns, each chosen to expose a different fault:
- Uniformly random samples exercise all three insertion cases: insertion below, at, or above the evicted slot.
- Rising ramps place the new sample at the top while the oldest sits low. Falling ramps give the reverse, which separates the shift-up path from the shift-down path.
- Constant runs and sparse impulses stress the placement of equal values, and test whether one-sided spikes pass the median.
- Signed data that crosses zero separates the two ordering modes.
- Random idle gaps show whether idle cycles disturb the window.
- Recursive runs after reset show whether preloaded zeros survive under refresh.
- Two-dimensional runs show whether outputs are spaced correctly.

// File: rtl/medf_pkg.sv
package medf_pkg;

    typedef enum logic [1:0] {
        SRC_SELF = 2'd0,
        SRC_LO   = 2'd1,
        SRC_HI   = 2'd2,
        SRC_NEW  = 2'd3
    } medf_src_e;

    function automatic int medf_age_bits(input int win);
        return $clog2(win) + 2;
    endfunction

endpackage

// File: rtl/medf_cmp.sv
module medf_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] stored_i,
    input  logic [W-1:0] sample_i,
    input  logic         signed_i,
    output logic         le_o
);
    always_comb begin
        if (signed_i) le_o = ($signed(stored_i) <= $signed(sample_i));
        else          le_o = (stored_i <= sample_i);
    end
endmodule

// File: rtl/medf_oldest.sv
module medf_oldest #(
    parameter int WIN = 9,
    parameter int AW  = 6
) (
    input  logic [WIN-1:0][AW-1:0] age_i,
    output logic [WIN-1:0]         below_o,
    output logic [WIN-1:0]         at_o
);
    localparam int IW = (WIN > 1) ? $clog2(WIN) : 1;

    logic [IW-1:0] best;
    logic [AW-1:0] best_age;

    always_comb begin
        best     = '0;
        best_age = age_i[0];
        for (int i = 1; i < WIN; i++) begin
            if (age_i[i] > best_age) begin
                best     = IW'(i);
                best_age = age_i[i];
            end
        end
        for (int i = 0; i < WIN; i++) begin
            below_o[i] = (IW'(i) < best);
            at_o[i]    = (IW'(i) == best);
        end
    end
endmodule

// File: rtl/medf_pe.sv
module medf_pe
    import medf_pkg::*;
#(
    parameter int W   = 8,
    parameter int AW  = 6,
    parameter int WIN = 9,
    parameter int IDX = 0
) (
    input  logic [W-1:0]  new_val_i,
    input  logic [W-1:0]  self_val_i,
    input  logic [W-1:0]  lo_val_i,
    input  logic [W-1:0]  hi_val_i,
    input  logic [AW-1:0] self_age_i,
    input  logic [AW-1:0] lo_age_i,
    input  logic [AW-1:0] hi_age_i,
    input  logic          le_self_i,
    input  logic          le_lo_i,
    input  logic          le_hi_i,
    input  logic          below_k_i,
    input  logic          at_k_i,
    output logic [W-1:0]  val_o,
    output logic [AW-1:0] age_o
);
    localparam logic [AW-1:0] AGE_TOP = '1;
    localparam bit IS_BOTTOM = (IDX == 0);
    localparam bit IS_TOP    = (IDX == WIN - 1);

    medf_src_e src;

    function automatic logic [AW-1:0] age_step(input logic [AW-1:0] a);
        return (a == AGE_TOP) ? a : a + 1'b1;
    endfunction

    always_comb begin
        if (below_k_i) begin
            if (le_self_i)                 src = SRC_SELF;
            else if (IS_BOTTOM || le_lo_i) src = SRC_NEW;
            else                           src = SRC_LO;
        end else if (at_k_i) begin
            if (!IS_BOTTOM && !le_lo_i)    src = SRC_LO;
            else if (!IS_TOP && le_hi_i)   src = SRC_HI;
            else                           src = SRC_NEW;
        end else begin
            if (!le_self_i)                src = SRC_SELF;
            else if (IS_TOP || !le_hi_i)   src = SRC_NEW;
            else                           src = SRC_HI;
        end
    end

    always_comb begin
        unique case (src)
            SRC_SELF: begin val_o = self_val_i; age_o = age_step(self_age_i); end
            SRC_LO:   begin val_o = lo_val_i;   age_o = age_step(lo_age_i);   end
            SRC_HI:   begin val_o = hi_val_i;   age_o = age_step(hi_age_i);   end
            default:  begin val_o = new_val_i;  age_o = '0;                   end
        endcase
    end
endmodule

// File: rtl/rank_median_filter.sv
module rank_median_filter
    import medf_pkg::*;
#(
    parameter int W         = 8,
    parameter int HALF      = 4,
    parameter int SHIFT_LEN = 3,
    localparam int WIN      = 2 * HALF + 1,
    localparam int RW       = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_data,
    input  logic          cfg_signed,
    input  logic          cfg_recursive,
    input  logic          cfg_2d,
    input  logic [RW-1:0] cfg_rank,
    output logic          out_valid,
    output logic [W-1:0]  out_data
);
    localparam int AW = medf_age_bits(WIN);
    localparam int CW = $clog2(WIN + 1);
    localparam int GW = (SHIFT_LEN > 1) ? $clog2(SHIFT_LEN) : 1;

    typedef struct packed {
        logic [WIN-1:0][W-1:0]  val;
        logic [WIN-1:0][AW-1:0] age;
        logic [CW-1:0]          fill;
        logic [GW-1:0]          grp;
        logic                   ov;
        logic [W-1:0]           od;
    } state_t;

    state_t st_d, st_q;

    logic [RW-1:0]            rank_idx;
    logic [WIN-1:0][AW-1:0]   age_eff;
    logic [WIN-1:0]           le_vec;
    logic [WIN-1:0]           below_k;
    logic [WIN-1:0]           at_k;
    logic [WIN+1:0][W-1:0]    val_pad;
    logic [WIN+1:0][AW-1:0]   age_pad;
    logic [WIN+1:0]           le_pad;
    logic [WIN-1:0][W-1:0]    pe_val;
    logic [WIN-1:0][AW-1:0]   pe_age;

    always_comb begin
        rank_idx = (cfg_rank > RW'(WIN - 1)) ? RW'(WIN - 1) : cfg_rank;
        for (int i = 0; i < WIN; i++) begin
            age_eff[i] = (cfg_recursive && (rank_idx == RW'(i))) ? '0 : st_q.age[i];
        end
    end

    generate
        for (genvar g = 0; g < WIN; g++) begin : g_cmp
            medf_cmp #(.W(W)) u_cmp (
                .stored_i (st_q.val[g]),
                .sample_i (in_data),
                .signed_i (cfg_signed),
                .le_o     (le_vec[g])
            );
        end
    endgenerate

    medf_oldest #(.WIN(WIN), .AW(AW)) u_oldest (
        .age_i   (age_eff),
        .below_o (below_k),
        .at_o    (at_k)
    );

    always_comb begin
        val_pad[0]       = st_q.val[0];
        age_pad[0]       = age_eff[0];
        le_pad[0]        = le_vec[0];
        val_pad[WIN+1]   = st_q.val[WIN-1];
        age_pad[WIN+1]   = age_eff[WIN-1];
        le_pad[WIN+1]    = le_vec[WIN-1];
        for (int i = 0; i < WIN; i++) begin
            val_pad[i+1] = st_q.val[i];
            age_pad[i+1] = age_eff[i];
            le_pad[i+1]  = le_vec[i];
        end
    end

    generate
        for (genvar g = 0; g < WIN; g++) begin : g_pe
            medf_pe #(.W(W), .AW(AW), .WIN(WIN), .IDX(g)) u_pe (
                .new_val_i  (in_data),
                .self_val_i (val_pad[g+1]),
                .lo_val_i   (val_pad[g]),
                .hi_val_i   (val_pad[g+2]),
                .self_age_i (age_pad[g+1]),
                .lo_age_i   (age_pad[g]),
                .hi_age_i   (age_pad[g+2]),
                .le_self_i  (le_pad[g+1]),
                .le_lo_i    (le_pad[g]),
                .le_hi_i    (le_pad[g+2]),
                .below_k_i  (below_k[g]),
                .at_k_i     (at_k[g]),
                .val_o      (pe_val[g]),
                .age_o      (pe_age[g])
            );
        end
    endgenerate

    always_comb begin
        logic filled_after;
        logic group_end;
        st_d         = st_q;
        st_d.ov      = 1'b0;
        filled_after = (st_q.fill >= CW'(WIN - 1));
        group_end    = (st_q.grp == GW'(SHIFT_LEN - 1));
        if (in_valid) begin
            st_d.val  = pe_val;
            st_d.age  = pe_age;
            st_d.fill = filled_after ? CW'(WIN) : st_q.fill + 1'b1;
            st_d.grp  = group_end ? '0 : st_q.grp + 1'b1;
            st_d.ov   = filled_after && (!cfg_2d || group_end);
            if (st_d.ov) st_d.od = pe_val[rank_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN; i++) begin
                st_q.val[i] <= '0;
                st_q.age[i] <= AW'(i);
            end
            st_q.fill <= '0;
            st_q.grp  <= '0;
            st_q.ov   <= 1'b0;
            st_q.od   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;

    function automatic logic window_ordered(input logic [WIN-1:0][W-1:0] v, input logic sg);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < WIN - 1; i++) begin
            if (sg ? ($signed(v[i]) > $signed(v[i+1])) : (v[i] > v[i+1])) ok = 1'b0;
        end
        return ok;
    endfunction

    logic [WIN-1:0] age_is_zero;
    always_comb begin
        for (int i = 0; i < WIN; i++) age_is_zero[i] = (st_q.age[i] == '0);
    end

    AST_WINDOW_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        window_ordered(st_q.val, cfg_signed)); // R1

    AST_ONE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_recursive) |=> ($countones(age_is_zero) == 1)); // R2

    AST_SINGLE_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ($onehot(at_k) && !(|(below_k & at_k)))); // R2

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_q.val) && $stable(st_q.age))); // R7

    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R6

    generate
        if (SHIFT_LEN > 1) begin : g_gap
            AST_2D_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_2d && out_valid) |=> !out_valid); // R9
        end
    endgenerate

endmodule

// File: tb/rank_median_filter_tb_top.sv
`timescale 1ns/1ps
module rank_median_filter_tb_top;
    localparam int W         = 8;
    localparam int HALF      = 4;
    localparam int SHIFT_LEN = 3;
    localparam int WIN       = 2 * HALF + 1;
    localparam int RW        = $clog2(WIN);
    localparam int AW        = $clog2(WIN) + 2;
    localparam int AGE_TOP   = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic          cfg_signed = 1'b0;
    logic          cfg_recursive = 1'b0;
    logic          cfg_2d = 1'b0;
    logic [RW-1:0] cfg_rank = RW'(HALF);
    logic          out_valid;
    logic [W-1:0]  out_data;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R5";
    int    mval[$];
    int    mage[$];
    int    fill_n, grp_n, exp_data;
    bit    exp_valid;

    always #2.5 clk = ~clk;

    rank_median_filter #(.W(W), .HALF(HALF), .SHIFT_LEN(SHIFT_LEN)) dut_i (
        .clk, .rst_n, .in_valid, .in_data, .cfg_signed, .cfg_recursive,
        .cfg_2d, .cfg_rank, .out_valid, .out_data
    );

    function automatic int rank_now();
        int r = int'(cfg_rank);
        return (r > WIN - 1) ? WIN - 1 : r;
    endfunction

    function automatic int as_int(input logic [W-1:0] v);
        return cfg_signed ? int'($signed(v)) : int'(v);
    endfunction

    function automatic int rnd_sample();
        int u = int'($urandom_range(0, (1 << W) - 1));
        return cfg_signed ? u - (1 << (W - 1)) : u;
    endfunction

    function automatic void model_reset();
        mval.delete();
        mage.delete();
        for (int i = 0; i < WIN; i++) begin
            mval.push_back(0);
            mage.push_back(i);
        end
        fill_n = 0; grp_n = 0; exp_valid = 1'b0; exp_data = 0;
    endfunction

    function automatic void model_step(input int x);
        int k = 0;
        int p = 0;
        if (cfg_recursive) mage[rank_now()] = 0;
        for (int i = 1; i < mage.size(); i++) if (mage[i] > mage[k]) k = i;
        mval.delete(k);
        mage.delete(k);
        foreach (mage[i]) if (mage[i] < AGE_TOP) mage[i]++;
        foreach (mval[i]) if (mval[i] <= x) p++;
        mval.insert(p, x);
        mage.insert(p, 0);
        if (fill_n < WIN) fill_n++;
        exp_valid = (fill_n == WIN) && (!cfg_2d || grp_n == SHIFT_LEN - 1);
        grp_n = (grp_n + 1) % SHIFT_LEN;
        exp_data = mval[rank_now()];
    endfunction

    task automatic check_outputs();
        total++;
        if (out_valid !== exp_valid) begin
            bad++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", cur_req, out_valid, exp_valid);
        end
        if (exp_valid) begin
            total++;
            if (as_int(out_data) !== exp_data) begin
                bad++;
                $display("FAIL %s out_data actual=%0d expected=%0d", cur_req, as_int(out_data), exp_data);
            end
        end
    endtask

    task automatic step(input bit v, input int x);
        @(negedge clk);
        check_outputs();
        in_valid = v;
        in_data  = W'(x);
        if (v) model_step(x);
        else   exp_valid = 1'b0;
    endtask

    task automatic do_reset(input bit sg, input bit rec, input bit td, input int rank);
        @(negedge clk);
        if (rst_n) check_outputs();
        rst_n = 1'b0; in_valid = 1'b0;
        cfg_signed = sg; cfg_recursive = rec; cfg_2d = td; cfg_rank = RW'(rank);
        repeat (2) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            bad++;
            $display("FAIL R5 reset outputs actual=%0b/%0d expected=0/0", out_valid, out_data);
        end
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic run_random(input int n, input int idle_pct);
        for (int i = 0; i < n; i++) begin
            bit v = (int'($urandom_range(0, 99)) >= idle_pct);
            step(v, rnd_sample());
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired in %s actual=running expected=finished", cur_req);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        do_reset(0, 0, 0, HALF);
        cur_req = "R6";
        for (int i = 0; i < WIN + 2; i++) step(1, 10 + i * 7);
        cur_req = "R2";
        run_random(200, 0);
        for (int i = 0; i < 30; i++) step(1, i * 8);
        for (int i = 0; i < 30; i++) step(1, 240 - i * 8);
        for (int i = 0; i < 20; i++) step(1, 77);
        for (int i = 0; i < 40; i++) step(1, (i % 5 == 0) ? 255 : 100 + (i % 3));
        cur_req = "R7";
        run_random(120, 50);
        cur_req = "R1";
        do_reset(0, 0, 0, 0);
        run_random(80, 10);
        do_reset(0, 0, 0, WIN - 1);
        run_random(80, 10);
        cur_req = "R3";
        do_reset(0, 0, 0, (1 << RW) - 1);
        run_random(60, 10);
        do_reset(0, 0, 0, 2);
        run_random(60, 10);
        cur_req = "R4";
        do_reset(1, 0, 0, HALF);
        run_random(200, 20);
        for (int i = 0; i < 30; i++) step(1, -60 + i * 4);
        cur_req = "R8";
        do_reset(0, 1, 0, HALF);
        run_random(200, 20);
        do_reset(1, 1, 0, 2);
        run_random(150, 20);
        cur_req = "R9";
        do_reset(0, 0, 1, HALF);
        run_random(150, 25);
        do_reset(0, 1, 1, HALF);
        run_random(100, 25);
        @(negedge clk);
        check_outputs();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule